// File: doc/BRIEF.md
# Keypad Command Sequencer for Remote Device Switching

This block sits behind a tone-dial digit decoder and an access-code check. Once the access stage raises `authorised_i`, each keypad digit arrives as a 4-bit code qualified by a level strobe. The block sorts each digit into one of three classes: a number, a switch-on command, or a switch-off command. The first number names a group and the second names a device inside that group. A following on or off command then drives the addressed output flip-flop high or low.

A third number in the command slot is a remote abort. It raises a reset request, which the surrounding system answers by dropping authorisation. After a completed command the sequencer goes back to waiting for a group digit. The user can therefore switch several devices one after another without entering the access code again. Codes that are not keys are dropped.

All logic is synchronous to one clock. The strobe is sampled, and its rising and falling edges are detected as single-cycle events. The slot counter moves on the rising edge. The digit value is written into the group or device register on the falling edge. Commands act on the rising edge.

Top module: `dtmf_cmd_seq`

## Requirements
- R1: Codes 0001 to 1010 are numbers, with the keypad zero sent as 1010 and meaning ten. Code 1011 is the switch-on key and code 1100 is the switch-off key.
- R2: Codes 0000 and 1101 to 1111 are ignored. They do not move the sequence, are not captured, and change no output.
- R3: An on or off command is visible on `dev_state_o` at the first clock edge where the strobe is sampled high after being sampled low. The outputs do not change while the strobe has not yet been sampled.
- R4: The first number after authorisation becomes the group and the second becomes the device. The command targets bit index (group-1)*DEVS_PER_GROUP + (device-1) of `dev_state_o`.
- R5: Switch-on sets the addressed bit and switch-off clears it. All other bits keep their value.
- R6: A command whose group exceeds NUM_GROUPS, or whose device exceeds DEVS_PER_GROUP, changes no bit. The sequence still returns to waiting for a group digit.
- R7: When the strobe of a command falls, the sequence waits for a new group digit. Further group, device and command sequences work without re-authorisation.
- R8: A number in the command slot raises `reset_req_o` and changes no bit. The request stays high, and all later digits are ignored, until `authorised_i` goes low.
- R9: While `authorised_i` is low, the sequence is held at its start, `reset_req_o` is low and digits are ignored. `dev_state_o` keeps its value.
- R10: An on or off command received before both a group and a device have been captured is ignored. It does not disturb the digits already captured.
- R11: A synchronous active-high `rst` clears `dev_state_o` and `reset_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| authorised_i | input | 1 | High while the access stage allows commands |
| key_strobe_i | input | 1 | High while a decoded digit is present |
| key_code_i | input | 4 | Decoded digit code |
| dev_state_o | output | NUM_GROUPS*DEVS_PER_GROUP | Device on/off flip-flops |
| reset_req_o | output | 1 | Remote abort request |

## Verification
A slot counter stuck one position off would show up at the ports within one key press. Either a command lands on a neighbouring device bit, or `reset_req_o` rises one digit early or late. A group or device register written on the wrong strobe edge would address the wrong bit on the next command. If the return to the start slot were missed, the first digit of the following sequence would raise an abort instead of selecting a group. The bench therefore strings several sequences together, adds ignored keys inside them, and checks the outputs after every key.

// File: rtl/dtmf_cmd_pkg.sv
`timescale 1ns/1ps
package dtmf_cmd_pkg;
  localparam int KEY_W = 4;
  localparam logic [KEY_W-1:0] KEY_ONE  = 4'b0001;
  localparam logic [KEY_W-1:0] KEY_ZERO = 4'b1010;
  localparam logic [KEY_W-1:0] KEY_ON   = 4'b1011;
  localparam logic [KEY_W-1:0] KEY_OFF  = 4'b1100;

  typedef enum logic [1:0] {CLS_NONE, CLS_NUM, CLS_ON, CLS_OFF} key_cls_t;

  // Slot counter: START waits for group, LOAD_GRP/LOAD_DEV mark the
  // register being filled, ABORT is the remote abort slot.
  typedef enum logic [1:0] {SEQ_START, SEQ_LOAD_GRP, SEQ_LOAD_DEV, SEQ_ABORT} seq_t;

  function automatic key_cls_t classify_key(input logic [KEY_W-1:0] k);
    if (k >= KEY_ONE && k <= KEY_ZERO) return CLS_NUM;
    else if (k == KEY_ON)              return CLS_ON;
    else if (k == KEY_OFF)             return CLS_OFF;
    else                               return CLS_NONE;
  endfunction
endpackage

// File: rtl/dtmf_key_edge.sv
`timescale 1ns/1ps
module dtmf_key_edge import dtmf_cmd_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_i,
  input  logic [KEY_W-1:0] code_i,
  output logic             lead_o,
  output logic             trail_o,
  output key_cls_t         lead_cls_o,
  output key_cls_t         trail_cls_o,
  output logic [KEY_W-1:0] held_code_o
);
  logic             strb_q;
  logic [KEY_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q <= 1'b0;
      code_q <= '0;
    end else begin
      strb_q <= strobe_i;
      if (strobe_i && !strb_q) code_q <= code_i;
    end
  end

  assign lead_o      = strobe_i & ~strb_q;
  assign trail_o     = ~strobe_i & strb_q;
  assign lead_cls_o  = classify_key(code_i);
  assign trail_cls_o = classify_key(code_q);
  assign held_code_o = code_q;
endmodule

// File: rtl/dtmf_seq_ctrl.sv
`timescale 1ns/1ps
module dtmf_seq_ctrl import dtmf_cmd_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             auth_i,
  input  logic             lead_i,
  input  logic             trail_i,
  input  key_cls_t         lead_cls_i,
  input  key_cls_t         trail_cls_i,
  input  logic [KEY_W-1:0] held_code_i,
  output logic [KEY_W-1:0] grp_o,
  output logic [KEY_W-1:0] dev_o,
  output logic             fire_o,
  output logic             fire_on_o,
  output logic             abort_o
);
  seq_t             seq_q, seq_d;
  logic [KEY_W-1:0] grp_q, dev_q;
  logic             lead_cmd, trail_cmd;

  assign lead_cmd  = (lead_cls_i == CLS_ON) || (lead_cls_i == CLS_OFF);
  assign trail_cmd = (trail_cls_i == CLS_ON) || (trail_cls_i == CLS_OFF);

  always_comb begin
    seq_d = seq_q;
    if (lead_i && lead_cls_i == CLS_NUM) begin
      case (seq_q)
        SEQ_START:    seq_d = SEQ_LOAD_GRP;
        SEQ_LOAD_GRP: seq_d = SEQ_LOAD_DEV;
        SEQ_LOAD_DEV: seq_d = SEQ_ABORT;
        default:      seq_d = seq_q;
      endcase
    end else if (trail_i && trail_cmd && seq_q == SEQ_LOAD_DEV) begin
      seq_d = SEQ_START;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !auth_i) begin
      seq_q <= SEQ_START;
      grp_q <= '0;
      dev_q <= '0;
    end else begin
      seq_q <= seq_d;
      if (trail_i && trail_cls_i == CLS_NUM) begin
        if (seq_q == SEQ_LOAD_GRP) grp_q <= held_code_i;
        if (seq_q == SEQ_LOAD_DEV) dev_q <= held_code_i;
      end
    end
  end

  assign grp_o     = grp_q;
  assign dev_o     = dev_q;
  assign fire_o    = auth_i && lead_i && lead_cmd && (seq_q == SEQ_LOAD_DEV);
  assign fire_on_o = (lead_cls_i == CLS_ON);
  assign abort_o   = (seq_q == SEQ_ABORT);
endmodule

// File: rtl/dtmf_dev_bank.sv
`timescale 1ns/1ps
module dtmf_dev_bank import dtmf_cmd_pkg::*; #(
  parameter int NUM_GROUPS     = 2,
  parameter int DEVS_PER_GROUP = 10
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 fire_i,
  input  logic                                 on_i,
  input  logic [KEY_W-1:0]                     grp_i,
  input  logic [KEY_W-1:0]                     dev_i,
  output logic [NUM_GROUPS*DEVS_PER_GROUP-1:0] state_o
);
  localparam int NUM_DEV = NUM_GROUPS * DEVS_PER_GROUP;

  logic [NUM_DEV-1:0] hit;
  logic [NUM_DEV-1:0] state_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar d = 0; d < DEVS_PER_GROUP; d++) begin : g_dev
      assign hit[g*DEVS_PER_GROUP + d] = fire_i
          && (grp_i == KEY_W'(g + 1))
          && (dev_i == KEY_W'(d + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= (state_q & ~hit) | (hit & {NUM_DEV{on_i}});
  end

  assign state_o = state_q;
endmodule

// File: rtl/dtmf_cmd_seq.sv
`timescale 1ns/1ps
module dtmf_cmd_seq import dtmf_cmd_pkg::*; #(
  parameter int NUM_GROUPS     = 2,
  parameter int DEVS_PER_GROUP = 10
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 authorised_i,
  input  logic                                 key_strobe_i,
  input  logic [3:0]                           key_code_i,
  output logic [NUM_GROUPS*DEVS_PER_GROUP-1:0] dev_state_o,
  output logic                                 reset_req_o
);
  localparam int NUM_DEV = NUM_GROUPS * DEVS_PER_GROUP;

  logic             lead, trail, fire, fire_on, abort_q;
  key_cls_t         lead_cls, trail_cls;
  logic [KEY_W-1:0] held_code, grp, dev;
  logic [NUM_DEV-1:0] bank_state;

  dtmf_key_edge u_edge (
    .clk(clk), .rst(rst), .strobe_i(key_strobe_i), .code_i(key_code_i),
    .lead_o(lead), .trail_o(trail), .lead_cls_o(lead_cls),
    .trail_cls_o(trail_cls), .held_code_o(held_code)
  );

  dtmf_seq_ctrl u_seq (
    .clk(clk), .rst(rst), .auth_i(authorised_i), .lead_i(lead), .trail_i(trail),
    .lead_cls_i(lead_cls), .trail_cls_i(trail_cls), .held_code_i(held_code),
    .grp_o(grp), .dev_o(dev), .fire_o(fire), .fire_on_o(fire_on), .abort_o(abort_q)
  );

  dtmf_dev_bank #(.NUM_GROUPS(NUM_GROUPS), .DEVS_PER_GROUP(DEVS_PER_GROUP)) u_bank (
    .clk(clk), .rst(rst), .fire_i(fire), .on_i(fire_on),
    .grp_i(grp), .dev_i(dev), .state_o(bank_state)
  );

  assign dev_state_o = bank_state;
  assign reset_req_o = abort_q;
endmodule

// File: rtl/dtmf_cmd_seq_chk.sv
`timescale 1ns/1ps
module dtmf_cmd_seq_chk #(
  parameter int NUM_DEV = 20
) (
  input logic               clk,
  input logic               rst,
  input logic               authorised_i,
  input logic               key_strobe_i,
  input logic [3:0]         key_code_i,
  input logic [NUM_DEV-1:0] dev_state_o,
  input logic               reset_req_o
);
  // R9: no abort request is held while access is withdrawn
  p_no_req_unauth_r9: assert property (@(posedge clk) disable iff (rst)
    !authorised_i |=> !reset_req_o);

  // R3: outputs move only after a sampled rising strobe while authorised
  p_change_on_lead_r3: assert property (@(posedge clk) disable iff (rst)
    (dev_state_o != $past(dev_state_o)) |->
      ($past(key_strobe_i) && !$past(key_strobe_i, 2) && $past(authorised_i)));

  // R5: at most one device bit changes per step
  p_one_bit_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(dev_state_o ^ $past(dev_state_o)) <= 1);

  // R5: a bit that rises came from the switch-on key
  p_rise_from_on_r5: assert property (@(posedge clk) disable iff (rst)
    ((dev_state_o & ~$past(dev_state_o)) != '0) |-> ($past(key_code_i) == 4'b1011));

  // R5: a bit that falls came from the switch-off key
  p_fall_from_off_r5: assert property (@(posedge clk) disable iff (rst)
    ((~dev_state_o & $past(dev_state_o)) != '0) |-> ($past(key_code_i) == 4'b1100));

  // R8: abort raised only by a sampled rising strobe of a number
  p_abort_numeric_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_req_o) |-> ($past(key_strobe_i) && !$past(key_strobe_i, 2)
      && $past(key_code_i) >= 4'd1 && $past(key_code_i) <= 4'd10));

  // R8: while aborted no device changes
  p_abort_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    reset_req_o |=> $stable(dev_state_o));

  // R2: a rising strobe with a non-key code changes nothing
  p_invalid_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (key_strobe_i && !$past(key_strobe_i)
      && (key_code_i == 4'd0 || key_code_i >= 4'd13))
      |=> ($stable(dev_state_o) && $stable(reset_req_o)));
endmodule

bind dtmf_cmd_seq dtmf_cmd_seq_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rst(rst), .authorised_i(authorised_i), .key_strobe_i(key_strobe_i),
  .key_code_i(key_code_i), .dev_state_o(dev_state_o), .reset_req_o(reset_req_o)
);

// File: tb/sim_dtmf_cmd_seq.sv
`timescale 1ns/1ps
module sim_dtmf_cmd_seq;
  localparam int NG = 2;
  localparam int ND = 10;
  localparam int NB = NG * ND;

  logic clk = 1'b0, rst = 1'b1, auth = 1'b0, strb = 1'b0;
  logic [3:0] code = 4'd0;
  logic [NB-1:0] dev_state;
  logic req;

  dtmf_cmd_seq #(.NUM_GROUPS(NG), .DEVS_PER_GROUP(ND)) u0 (
    .clk(clk), .rst(rst), .authorised_i(auth), .key_strobe_i(strb),
    .key_code_i(code), .dev_state_o(dev_state), .reset_req_o(req)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [NB:0] exp_q[$];
  string tag_q[$];
  event ev_chk;

  // requirement model
  logic [NB-1:0] m_state = '0;
  logic m_req = 1'b0;
  int m_pos = 0, m_grp = 0, m_dev = 0;

  task automatic apply_key(input logic [3:0] c);
    if (!auth) return;
    if (c >= 4'd1 && c <= 4'd10) begin
      case (m_pos)
        0: begin m_grp = int'(c); m_pos = 1; end
        1: begin m_dev = int'(c); m_pos = 2; end
        2: begin m_req = 1'b1; m_pos = 3; end
        default: ;
      endcase
    end else if ((c == 4'd11 || c == 4'd12) && m_pos == 2) begin
      if (m_grp >= 1 && m_grp <= NG && m_dev >= 1 && m_dev <= ND)
        m_state[(m_grp-1)*ND + m_dev - 1] = (c == 4'd11);
      m_pos = 0;
    end
  endtask

  task automatic push_expect(input string tag);
    exp_q.push_back({m_req, m_state});
    tag_q.push_back(tag);
    -> ev_chk;
  endtask

  task automatic press(input logic [3:0] c, input string tag);
    @(negedge clk); code = c; strb = 1'b1;
    repeat (3) @(negedge clk);
    strb = 1'b0;
    repeat (2) @(negedge clk);
    apply_key(c);
    push_expect(tag);
  endtask

  // R3: checks the exact cycle of the output change
  task automatic press_timed(input logic [3:0] c);
    @(negedge clk); code = c; strb = 1'b1;
    push_expect("R3 before strobe sampled");
    @(negedge clk);
    apply_key(c);
    push_expect("R3 one edge after strobe rise");
    repeat (2) @(negedge clk);
    strb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic seq3(input logic [3:0] a, input logic [3:0] b,
                      input logic [3:0] c, input string tag);
    press(a, tag); press(b, tag); press(c, tag);
  endtask

  initial begin : monitor
    logic [NB:0] e;
    string t;
    forever begin
      @(ev_chk);
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({req, dev_state} !== e) begin
          errors++;
          $display("FAIL %s: got req=%0b state=%h, expected req=%0b state=%h",
                   t, req, dev_state, e[NB], e[NB-1:0]);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    push_expect("R11 reset state");
    rst = 1'b0; auth = 1'b1;
    @(negedge clk);

    seq3(4'd1, 4'd1, 4'd11, "R4 R5 group1 device1 on");
    seq3(4'd2, 4'd10, 4'd11, "R1 zero key as ten");
    seq3(4'd1, 4'd5, 4'd11, "R7 next sequence without reauth");
    seq3(4'd1, 4'd1, 4'd12, "R5 off clears only addressed bit");

    press(4'd11, "R10 on before group");
    press(4'd2, "R10 group digit");
    press(4'd12, "R10 off before device");
    press(4'd3, "R10 device digit");
    press(4'd11, "R10 command after ignored keys");

    press(4'd1, "R2 group");
    press(4'd15, "R2 code 1111 ignored");
    press(4'd2, "R2 device");
    press(4'd0, "R2 code 0000 ignored");
    press(4'd13, "R2 code 1101 ignored");
    press(4'd11, "R2 command after invalid codes");

    seq3(4'd3, 4'd4, 4'd11, "R6 group out of range");
    seq3(4'd1, 4'd7, 4'd11, "R6 sequence restarted after range miss");

    press(4'd1, "R3 group");
    press(4'd9, "R3 device");
    press_timed(4'd11);

    seq3(4'd2, 4'd2, 4'd5, "R8 third number aborts");
    press(4'd11, "R8 command during abort ignored");
    press(4'd1, "R8 number during abort ignored");

    @(negedge clk); auth = 1'b0;
    repeat (3) @(negedge clk);
    m_pos = 0; m_req = 1'b0; m_grp = 0; m_dev = 0;
    push_expect("R9 request drops with access");
    seq3(4'd1, 4'd5, 4'd12, "R9 keys ignored without access");
    @(negedge clk); auth = 1'b1;
    @(negedge clk);
    seq3(4'd1, 4'd5, 4'd12, "R9 fresh sequence after reauth");

    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    m_state = '0; m_req = 1'b0; m_pos = 0;
    push_expect("R11 reset clears outputs");
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule